// File: doc/BRIEF.md
# Three-Phase Current Rebuild from Two Shunt Samples

Bottom-side shunts in a three-phase inverter can only be read while that phase's lower switch conducts. The phase with the highest commanded voltage has the shortest lower-switch on-time, so its sample may be taken before the reading has settled. This block takes the three signed duty commands and the three signed ADC current samples for a PWM period. It finds the phase with the highest command and drops that phase's sample. In its place it writes the negated sum of the other two samples, because the three phase currents always sum to zero.

The ranking of the three duty values also yields a sector number from 1 to 6. Each sector covers 60 electrical degrees. The results and the sector are registered, and an output strobe marks them one clock after the input strobe.

Top module: `phase_current_rebuild`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted input, `out_valid` is 0, all three current outputs are 0 and `sector` is 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was 1, and 0 otherwise. Results appear on that same cycle.
- R3: The sector is encoded by the order of the duty values, from highest to lowest: A>B>C is 1, B>A>C is 2, B>C>A is 3, C>B>A is 4, C>A>B is 5, A>C>B is 6.
- R4: When duty values are equal, A ranks above B and B ranks above C. This applies to both the top position and the middle position.
- R5: In sectors 1 and 6, `cur_a` is the negated sum of `samp_b` and `samp_c`, and `cur_b` and `cur_c` equal their samples.
- R6: In sectors 2 and 3, `cur_b` is the negated sum of `samp_a` and `samp_c`, and the other two outputs equal their samples.
- R7: In sectors 4 and 5, `cur_c` is the negated sum of `samp_a` and `samp_b`, and the other two outputs equal their samples.
- R8: A rebuilt current that falls outside the signed CUR_W range saturates. It becomes the largest positive value (32767 at 16 bits) or the most negative value (-32768).
- R9: While `in_valid` is 0, the duty and sample inputs are ignored and the outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a valid set of duty values and samples |
| duty_a | input | DUTY_W | Signed duty command, phase A |
| duty_b | input | DUTY_W | Signed duty command, phase B |
| duty_c | input | DUTY_W | Signed duty command, phase C |
| samp_a | input | CUR_W | Signed current sample, phase A |
| samp_b | input | CUR_W | Signed current sample, phase B |
| samp_c | input | CUR_W | Signed current sample, phase C |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| cur_a | output | CUR_W | Signed current, phase A |
| cur_b | output | CUR_W | Signed current, phase B |
| cur_c | output | CUR_W | Signed current, phase C |
| sector | output | 3 | Sector number 1..6, or 0 after reset |

## Verification
The hardest cases to reach are the edges of the ranking and of the arithmetic. These are duty values that tie exactly, and sample pairs whose negated sum does not fit the output width. In ordinary sinusoidal operation, ties appear only for a single sample and full-scale samples are rare. The stimulus therefore drives each tie pattern on purpose: all three equal, and each pair equal above or below the third. It also pushes both remaining samples to full scale in each direction, which drives the rebuilt phase into positive and negative saturation.

// File: rtl/phase_current_rebuild.sv
module phase_current_rebuild #(
  parameter int DUTY_W = 16,
  parameter int CUR_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DUTY_W-1:0] duty_a,
  input  logic signed [DUTY_W-1:0] duty_b,
  input  logic signed [DUTY_W-1:0] duty_c,
  input  logic signed [CUR_W-1:0]  samp_a,
  input  logic signed [CUR_W-1:0]  samp_b,
  input  logic signed [CUR_W-1:0]  samp_c,
  output logic                     out_valid,
  output logic signed [CUR_W-1:0]  cur_a,
  output logic signed [CUR_W-1:0]  cur_b,
  output logic signed [CUR_W-1:0]  cur_c,
  output logic [2:0]               sector
);
  localparam int SUM_W = CUR_W + 2;
  localparam logic signed [SUM_W-1:0] CUR_MAX = {3'b000, {(CUR_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] CUR_MIN = {3'b111, {(CUR_W-1){1'b0}}};

  logic a_top, b_top;
  logic [2:0] sec_d;

  assign a_top = (duty_a >= duty_b) && (duty_a >= duty_c);
  assign b_top = !a_top && (duty_b >= duty_c);

  always_comb begin
    if (a_top)      sec_d = (duty_b >= duty_c) ? 3'd1 : 3'd6;
    else if (b_top) sec_d = (duty_a >= duty_c) ? 3'd2 : 3'd3;
    else            sec_d = (duty_a >= duty_b) ? 3'd5 : 3'd4;
  end

  logic signed [SUM_W-1:0] xa, xb, xc, neg_sum;
  logic signed [CUR_W-1:0] rebuilt;

  assign xa = {{2{samp_a[CUR_W-1]}}, samp_a};
  assign xb = {{2{samp_b[CUR_W-1]}}, samp_b};
  assign xc = {{2{samp_c[CUR_W-1]}}, samp_c};

  always_comb begin
    if (a_top)      neg_sum = -(xb + xc);
    else if (b_top) neg_sum = -(xa + xc);
    else            neg_sum = -(xa + xb);
  end

  assign rebuilt = (neg_sum > CUR_MAX) ? CUR_MAX[CUR_W-1:0] :
                   (neg_sum < CUR_MIN) ? CUR_MIN[CUR_W-1:0] :
                   neg_sum[CUR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cur_a     <= '0;
      cur_b     <= '0;
      cur_c     <= '0;
      sector    <= 3'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cur_a  <= a_top ? rebuilt : samp_a;
        cur_b  <= b_top ? rebuilt : samp_b;
        cur_c  <= (!a_top && !b_top) ? rebuilt : samp_c;
        sector <= sec_d;
      end
    end
  end
endmodule

// File: rtl/phase_current_rebuild_chk.sv
module phase_current_rebuild_chk #(
  parameter int DUTY_W = 16,
  parameter int CUR_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DUTY_W-1:0] duty_a,
  input logic signed [DUTY_W-1:0] duty_b,
  input logic signed [DUTY_W-1:0] duty_c,
  input logic signed [CUR_W-1:0]  samp_a,
  input logic signed [CUR_W-1:0]  samp_b,
  input logic signed [CUR_W-1:0]  samp_c,
  input logic                     out_valid,
  input logic signed [CUR_W-1:0]  cur_a,
  input logic signed [CUR_W-1:0]  cur_b,
  input logic signed [CUR_W-1:0]  cur_c,
  input logic [2:0]               sector
);
  localparam logic signed [CUR_W-1:0] MAXV = {1'b0, {(CUR_W-1){1'b1}}};
  localparam logic signed [CUR_W-1:0] MINV = {1'b1, {(CUR_W-1){1'b0}}};

  logic signed [CUR_W+1:0] tot;
  assign tot = $signed({{2{cur_a[CUR_W-1]}}, cur_a}) + $signed({{2{cur_b[CUR_W-1]}}, cur_b})
             + $signed({{2{cur_c[CUR_W-1]}}, cur_c});

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  p_sector_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sector >= 3'd1 && sector <= 3'd6));
  p_a_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sector == 3'd1 || sector == 3'd6) |->
      ($past(duty_a) >= $past(duty_b) && $past(duty_a) >= $past(duty_c)));
  p_zero_sum_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sector == 3'd1 || sector == 3'd6) && cur_a != MAXV && cur_a != MINV |-> tot == '0);
  p_zero_sum_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sector == 3'd2 || sector == 3'd3) && cur_b != MAXV && cur_b != MINV |-> tot == '0);
  p_zero_sum_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sector == 3'd4 || sector == 3'd5) && cur_c != MAXV && cur_c != MINV |-> tot == '0);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(cur_a) && $stable(cur_b) && $stable(cur_c) && $stable(sector)));
endmodule

bind phase_current_rebuild phase_current_rebuild_chk #(.DUTY_W(DUTY_W), .CUR_W(CUR_W)) u_chk (.*);

// File: tb/test_phase_current_rebuild.sv
module test_phase_current_rebuild;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic signed [15:0] duty_a = 0, duty_b = 0, duty_c = 0;
  logic signed [15:0] samp_a = 0, samp_b = 0, samp_c = 0;
  logic out_valid;
  logic signed [15:0] cur_a, cur_b, cur_c;
  logic [2:0] sector;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_current_rebuild i_phase_current_rebuild (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int exp_sector(input int a, input int b, input int c);
    int ra, rb, rc;
    ra = (a >= b) + (a >= c);
    rb = (b > a) + (b >= c);
    rc = (c > a) + (c > b);
    if (ra == 2) return (rb == 1) ? 1 : 6;
    if (rb == 2) return (ra == 1) ? 2 : 3;
    return (ra == 1) ? 5 : 4;
  endfunction

  int ea, eb, ec, es;

  task automatic apply(input int da, input int db, input int dc,
                       input int sa, input int sb, input int sc, input string req);
    @(negedge clk);
    duty_a = 16'(da); duty_b = 16'(db); duty_c = 16'(dc);
    samp_a = 16'(sa); samp_b = 16'(sb); samp_c = 16'(sc);
    in_valid = 1;
    es = exp_sector(da, db, dc);
    ea = sa; eb = sb; ec = sc;
    if (es == 1 || es == 6) ea = sat16(-(sb + sc));
    else if (es == 2 || es == 3) eb = sat16(-(sa + sc));
    else ec = sat16(-(sa + sb));
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1, "R2 strobe", int'(out_valid), 1);
    chk(int'(sector) == es, {req, " sector"}, int'(sector), es);
    chk(int'(cur_a) == ea, {req, " cur_a"}, int'(cur_a), ea);
    chk(int'(cur_b) == eb, {req, " cur_b"}, int'(cur_b), eb);
    chk(int'(cur_c) == ec, {req, " cur_c"}, int'(cur_c), ec);
    @(negedge clk);
    chk(out_valid == 0, "R2 single strobe", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(cur_a == 0 && cur_b == 0 && cur_c == 0, "R1 currents", int'(cur_a), 0);
    chk(sector == 0, "R1 sector", int'(sector), 0);
  endtask

  task automatic t_sectors;
    apply(900, 100, -800, 120, -50, -60, "R3 R5 s1");
    apply(700, 800, -900, 30, 200, -210, "R3 R6 s2");
    apply(-900, 800, 100, -300, 999, 250, "R3 R6 s3");
    apply(-900, 100, 700, -40, 15, 333, "R3 R7 s4");
    apply(100, -900, 800, 77, -120, 5, "R3 R7 s5");
    apply(800, -900, 100, -1000, 600, 350, "R3 R5 s6");
  endtask

  task automatic t_ties;
    apply(5, 5, 5, 10, 20, 30, "R4 all equal");
    apply(300, 300, -600, 11, 22, 33, "R4 a=b top");
    apply(-600, 300, 300, 44, 55, 66, "R4 b=c top");
    apply(300, -600, 300, 1, 2, 3, "R4 a=c top");
    apply(-300, -300, 600, 7, 8, 9, "R4 a=b below c");
  endtask

  task automatic t_saturate;
    apply(1000, 0, -1000, 0, -32768, -32768, "R8 positive sat");
    apply(1000, 0, -1000, 0, 32767, 32767, "R8 negative sat");
    apply(-1000, 0, 1000, -32768, -32768, 0, "R8 c positive sat");
  endtask

  task automatic t_hold;
    apply(-900, 800, 100, 10, 20, 30, "R9 setup");
    for (int i = 0; i < 3; i++) begin
      duty_a = 16'(1000 + i); duty_b = -16'sd1000; duty_c = 0;
      samp_a = 16'(500 + i); samp_b = -16'sd7; samp_c = 16'sd9;
      @(negedge clk);
      chk(out_valid == 0, "R9 no strobe", int'(out_valid), 0);
      chk(sector == 3'd3, "R9 sector held", int'(sector), 3);
      chk(cur_a == 10 && cur_b == -40 && cur_c == 30, "R9 currents held", int'(cur_b), -40);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_sectors;
    t_ties;
    t_saturate;
    t_hold;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule